// File: doc/BRIEF.md
# IQ Gain Balancer

This block removes the gain mismatch between the in-phase and quadrature paths of a complex sample stream. The I path goes through unchanged. The Q path is scaled by `1 + c`, where `c` is a small signed gain-error coefficient. The multiply-add is rounded, then saturated back to the sample width.

When adaptation is enabled, the block compares the two paths. It accumulates `|Q| - |I|` over a window of `2^(12+code)` samples, which works as a first-order integrate-and-dump filter. At the end of each window the coefficient moves one step against the sign of the accumulated sum. A larger loop-bandwidth code gives a longer window and a slower, quieter loop. When adaptation is disabled, the coefficient follows a manual value supplied by the host. Adaptation restarts from that manual value when it is enabled again. The coefficient in use is always visible on an output.

Top module: `iq_gain_balancer`

## Requirements
- R1: `i_out` equals `i_in` delayed by exactly two clock cycles.
- R2: `q_out` is computed from `q`, the Q sample taken at a clock edge, and `c`, the coefficient held in the register just before that same edge. It equals `sat(q + ((q*c + 32768) >>> 16))` and appears two cycles after the sample is taken. Saturation limits the result to the range -32768 to 32767.
- R3: The coefficient is a 14-bit two's complement value in units of 2^-16. The applied gain is therefore `1 + c/65536`, which spans 0.875 up to just under 1.125.
- R4: While `adapt_en` is high, the block sums `|q_in| - |i_in|` over windows of `2^(12+bw_code)` samples. At the last sample of each window the coefficient changes as follows:
  - If the sum is positive, it decreases by 1.
  - If the sum is negative, it increases by 1.
  - If the sum is zero, it is unchanged.
  The coefficient never changes inside a window.
- R5: Adaptation clamps the coefficient at -8192 and at 8191. A step beyond either limit leaves the coefficient at that limit.
- R6: While `adapt_en` is low:
  - The coefficient register loads `coef_man` at every clock edge, so the new value is visible one cycle later.
  - The window sum and the sample counter are cleared.
  When adaptation is enabled again, the first window is a full window that starts from the last manual value.
- R7: A synchronous active-high `rst` sets the coefficient, `i_out` and `q_out` to zero. Reset takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample pair per cycle |
| rst | input | 1 | Synchronous reset, active high |
| adapt_en | input | 1 | 1 = adapt the coefficient, 0 = follow `coef_man` |
| bw_code | input | 4 | Loop-bandwidth code; window is 2^(12+code), codes above 11 act as 11 |
| coef_man | input | 14 | Manual gain-error coefficient, signed, units of 2^-16 |
| i_in | input | 16 | In-phase sample, signed |
| q_in | input | 16 | Quadrature sample, signed |
| i_out | output | 16 | In-phase sample, delayed by two cycles |
| q_out | output | 16 | Gain-corrected quadrature sample |
| coef_out | output | 14 | Coefficient currently applied to Q |

## Verification
Several properties are checked on every cycle:
- The two-cycle I pass-through.
- Q passing through untouched whenever the coefficient is zero.
- The coefficient tracking `coef_man` while adaptation is off.
- The coefficient staying still between window ends.
- The coefficient holding at the clamp limits.
- The window counter and sum being cleared while idle.

Other behaviour is shown only by the bench's scenarios, because it depends on the arithmetic of whole windows:
- The exact rounded and saturated Q values under random and extreme data.
- The exact cycle on which a window closes for different codes.
- The direction of each step for mixed-sign inputs.
- The restart of a window after a disable.

// File: rtl/iqgb_pkg.sv
package iqgb_pkg;

  // Direction the coefficient takes at the end of a window
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // log2 of the window length selected by a bandwidth code
  function automatic int unsigned win_log2(input int unsigned code,
                                           input int unsigned base,
                                           input int unsigned max_code);
    int unsigned c;
    c = (code > max_code) ? max_code : code;
    return base + c;
  endfunction

endpackage

// File: rtl/iqgb_mismatch_est.sv
module iqgb_mismatch_est
  import iqgb_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CODE_W    = 4,
  parameter int BASE_LOG2 = 12,
  parameter int MAX_CODE  = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [CODE_W-1:0]        bw_code,
  input  logic signed [DW-1:0]     i_in,
  input  logic signed [DW-1:0]     q_in,
  output step_e                    step
);

  localparam int CNTW = BASE_LOG2 + MAX_CODE + 1;
  localparam int MW   = DW + 1;
  localparam int DFW  = DW + 2;
  localparam int AW   = DFW + CNTW;

  logic signed [MW-1:0]  i_ext, q_ext;
  logic [MW-1:0]         mag_i, mag_q;
  logic signed [DFW-1:0] diff;
  logic signed [AW-1:0]  acc, sum_now;
  logic [CNTW-1:0]       cnt, last_idx;
  logic                  win_end;

  // Magnitudes are one bit wider so that the most negative sample still fits
  always_comb begin
    i_ext = MW'(i_in);
    q_ext = MW'(q_in);
    mag_i = i_ext[MW-1] ? -i_ext : i_ext;
    mag_q = q_ext[MW-1] ? -q_ext : q_ext;
    diff  = $signed({1'b0, mag_q}) - $signed({1'b0, mag_i});
  end

  always_comb begin
    last_idx = (CNTW'(1) << win_log2(int'(bw_code), BASE_LOG2, MAX_CODE)) - CNTW'(1);
    win_end  = (cnt >= last_idx);
    sum_now  = acc + AW'(diff);
  end

  always_comb begin
    step = STEP_HOLD;
    if (en && win_end) begin
      if (sum_now > 0)      step = STEP_DOWN;
      else if (sum_now < 0) step = STEP_UP;
    end
  end

  // First-order integrate and dump
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc <= '0;
      cnt <= '0;
    end else if (win_end) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= sum_now;
      cnt <= cnt + CNTW'(1);
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && acc == '0)); // R6

  AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_HOLD) |-> en); // R4

endmodule

// File: rtl/iqgb_coef_reg.sv
module iqgb_coef_reg
  import iqgb_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [CW-1:0] coef_man,
  input  step_e                step,
  output logic signed [CW-1:0] coef
);

  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      coef <= '0;
    end else if (!en) begin
      coef <= coef_man;
    end else begin
      unique case (step)
        STEP_DOWN: if (coef != CMIN) coef <= coef - CW'(1);
        STEP_UP:   if (coef != CMAX) coef <= coef + CW'(1);
        default:   coef <= coef;
      endcase
    end
  end

  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (rst)
    !en |=> (coef == $past(coef_man))); // R6

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && step == STEP_HOLD) |=> $stable(coef)); // R4

  AST_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (en && coef == CMIN && step == STEP_DOWN) |=> (coef == CMIN)); // R5

  AST_CEILING: assert property (@(posedge clk) disable iff (rst)
    (en && coef == CMAX && step == STEP_UP) |=> (coef == CMAX)); // R5

endmodule

// File: rtl/iqgb_gain_path.sv
module iqgb_gain_path #(
  parameter int DW   = 16,
  parameter int CW   = 14,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out
);

  localparam int PW = DW + CW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HALF_LSB = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] SMAX     = (SW'(1) << (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] SMIN     = -(SW'(1) << (DW - 1));

  logic signed [PW-1:0] prod_q;
  logic signed [DW-1:0] i_q1, q_q1;
  logic signed [SW-1:0] biased, scaled, total;
  logic [1:0]           warm;

  // Stage 1: product of Q and coefficient
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      i_q1   <= '0;
      q_q1   <= '0;
    end else begin
      prod_q <= PW'(q_in) * PW'(coef);
      i_q1   <= i_in;
      q_q1   <= q_in;
    end
  end

  always_comb begin
    biased = SW'(prod_q) + HALF_LSB;
    scaled = biased >>> FRAC;
    total  = scaled + SW'(q_q1);
  end

  // Stage 2: add back, saturate
  always_ff @(posedge clk) begin
    if (rst) begin
      i_out <= '0;
      q_out <= '0;
      warm  <= '0;
    end else begin
      i_out <= i_q1;
      warm  <= {warm[0], 1'b1};
      if (total > SMAX)      q_out <= SMAX[DW-1:0];
      else if (total < SMIN) q_out <= SMIN[DW-1:0];
      else                   q_out <= total[DW-1:0];
    end
  end

  AST_I_PASS: assert property (@(posedge clk) disable iff (rst)
    warm[1] |-> (i_out == $past(i_in, 2))); // R1

  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst)
    (warm[1] && $past(coef, 2) == '0) |-> (q_out == $past(q_in, 2))); // R2

endmodule

// File: rtl/iq_gain_balancer.sv
module iq_gain_balancer
  import iqgb_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 14,
  parameter int FRAC      = 16,
  parameter int CODE_W    = 4,
  parameter int BASE_LOG2 = 12,
  parameter int MAX_CODE  = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adapt_en,
  input  logic [CODE_W-1:0]    bw_code,
  input  logic signed [CW-1:0] coef_man,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out,
  output logic signed [CW-1:0] coef_out
);

  step_e                step;
  logic signed [CW-1:0] coef;

  iqgb_mismatch_est #(
    .DW(DW), .CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)
  ) u_est (
    .clk(clk), .rst(rst), .en(adapt_en), .bw_code(bw_code),
    .i_in(i_in), .q_in(q_in), .step(step)
  );

  iqgb_coef_reg #(.CW(CW)) u_coef (
    .clk(clk), .rst(rst), .en(adapt_en), .coef_man(coef_man),
    .step(step), .coef(coef)
  );

  iqgb_gain_path #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_path (
    .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in), .coef(coef),
    .i_out(i_out), .q_out(q_out)
  );

  assign coef_out = coef;

endmodule

// File: tb/iq_gain_balancer_tb_top.sv
module iq_gain_balancer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rst, adapt_en;
  logic [3:0]         bw_code;
  logic signed [13:0] coef_man, coef_out;
  logic signed [15:0] i_in, q_in, i_out, q_out;

  iq_gain_balancer dut_i (
    .clk(clk), .rst(rst), .adapt_en(adapt_en), .bw_code(bw_code),
    .coef_man(coef_man), .i_in(i_in), .q_in(q_in),
    .i_out(i_out), .q_out(q_out), .coef_out(coef_out)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  longint model_c;
  longint prev_i, prev_q;
  bit     prev_valid;

  task automatic check_eq(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_q(input longint q, input longint c);
    longint r, s;
    r = (q * c + 32768) >>> 16;
    s = q + r;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  // One cycle with adaptation off; checks the previous sample's outputs
  task automatic drive_cycle(input logic signed [15:0] iv,
                             input logic signed [15:0] qv,
                             input logic signed [13:0] mv);
    longint cur_i, cur_q;
    i_in = iv; q_in = qv; coef_man = mv;
    cur_i = longint'(iv);
    cur_q = exp_q(longint'(qv), model_c);
    @(posedge clk);
    model_c = longint'(mv);
    @(negedge clk);
    check_eq("R6 manual coef", longint'(coef_out), model_c);
    if (prev_valid) begin
      check_eq("R1 i pass", longint'(i_out), prev_i);
      check_eq("R2 q gain", longint'(q_out), prev_q);
    end
    prev_i = cur_i; prev_q = cur_q; prev_valid = 1'b1;
  endtask

  task automatic win_test(input string req, input logic [3:0] code,
                          input logic signed [13:0] start,
                          input logic signed [15:0] qv, input logic signed [15:0] iv,
                          input longint exp1, input longint exp2);
    int n;
    adapt_en = 1'b0; coef_man = start; q_in = qv; i_in = iv;
    repeat (2) @(negedge clk);
    adapt_en = 1'b1; bw_code = code;
    n = 1 << (12 + int'(code));
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    check_eq({req, " R4 hold in window"}, longint'(coef_out), longint'(start));
    @(posedge clk); @(negedge clk);
    check_eq({req, " first window"}, longint'(coef_out), exp1);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    check_eq({req, " R4 hold second window"}, longint'(coef_out), exp1);
    @(posedge clk); @(negedge clk);
    check_eq({req, " second window"}, longint'(coef_out), exp2);
    adapt_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst = 1'b1; adapt_en = 1'b1; bw_code = 4'd0;
    coef_man = 14'sd1234; i_in = 16'sd500; q_in = -16'sd700;
    repeat (4) @(negedge clk);
    // R7: reset dominates adaptation and manual value
    check_eq("R7 coef reset", longint'(coef_out), 0);
    check_eq("R7 i_out reset", longint'(i_out), 0);
    check_eq("R7 q_out reset", longint'(q_out), 0);
    adapt_en = 1'b0;
    rst = 1'b0;
    model_c = 0; prev_valid = 1'b0;

    // Random data with random manual coefficient (R1, R2, R3, R6)
    for (int k = 0; k < 1500; k++) begin
      drive_cycle(16'($urandom), 16'($urandom), 14'($urandom));
    end
    // Directed extremes: saturation and rounding corners (R2, R3)
    drive_cycle(16'sd100,    16'sd32767,  14'sd8191);
    drive_cycle(16'sd0,      -16'sd32768, 14'sd8191);
    drive_cycle(-16'sd1,     -16'sd32768, -14'sd8192);
    drive_cycle(16'sd7,      16'sd32767,  -14'sd8192);
    drive_cycle(16'sd3,      16'sd1,      14'sd0);
    drive_cycle(16'sd3,      16'sd4,      14'sd0);
    drive_cycle(16'sd3,      -16'sd3,     14'sd0);

    // Adaptation windows (R4, R5)
    win_test("R4 q>i code0", 4'd0, 14'sd100, 16'sd2000, 16'sd1000, 99, 98);
    win_test("R4 q<i code1", 4'd1, -14'sd50, -16'sd1000, 16'sd3000, -49, -48);
    win_test("R4 equal mags", 4'd0, 14'sd5, -16'sd700, 16'sd700, 5, 5);
    win_test("R5 floor", 4'd0, -14'sd8192, 16'sd900, -16'sd100, -8192, -8192);
    win_test("R5 ceiling", 4'd0, 14'sd8191, -16'sd5, -16'sd32768, 8191, 8191);

    // Disable mid-window restarts the window (R6)
    coef_man = 14'sd0; q_in = 16'sd400; i_in = 16'sd100;
    repeat (2) @(negedge clk);
    adapt_en = 1'b1; bw_code = 4'd0;
    repeat (3000) @(posedge clk);
    @(negedge clk);
    adapt_en = 1'b0;
    @(posedge clk); @(negedge clk);
    adapt_en = 1'b1;
    repeat (4095) @(posedge clk);
    @(negedge clk);
    check_eq("R6 window restarted", longint'(coef_out), 0);
    @(posedge clk); @(negedge clk);
    check_eq("R6 full window after restart", longint'(coef_out), -1);
    adapt_en = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule